// File: doc/BRIEF.md
# Dual Serial Converter Read Sequencer

This block sits on the host side of two 16-bit successive-approximation converters. The two converters share one conversion-start wire, one serial clock and one serial data line, and each has its own active-low select. When a sample request arrives while the sequencer is idle, it raises the conversion-start wire and counts a fixed worst-case conversion time in system clocks. It then reads converter one over the shared line, lets go of it, and reads converter two. Both words are presented together with a one-cycle strobe.

The serial clock is derived from the system clock by a parameter divider. The clock idles high and each falling edge both samples the current bit and tells the converter to move on to the next one. Each converter puts its most significant bit on the line as soon as its select falls. It lets go of the line after the sixteenth falling edge. The result interface is a plain valid pulse with no ready input, so it applies no back-pressure: the consumer must take both words in the cycle the strobe is high. The words stay in their registers until the next pair replaces them.

Top module: `dual_sar_reader`

## Requirements
- R1: After reset both selects are high, the serial clock is high, conversion-start is low, and busy and valid are low.
- R2: A request seen while idle raises conversion-start and busy after the next clock edge. Conversion-start stays high until the result pair is delivered.
- R3: Converter one's select falls exactly CONV_CYC system clocks after conversion-start rises, and never earlier.
- R4: During each select-low window the serial clock has exactly DATA_W falling edges, with a period of SCLK_DIV system clocks.
- R5: The bit on the data line just before each serial-clock fall is captured. The first capture is the most significant bit, so a converter holding word W yields W unchanged.
- R6: The two selects are never low together. Converter two's select falls only after converter one's select has risen, with at least one system clock in which both are high.
- R7: Conversion-start is never low while either select is low.
- R8: Both results are updated in the same cycle as a valid pulse that lasts exactly one cycle. res1_o carries the word from the converter read first.
- R9: A request that arrives while busy is ignored: it gives no extra conversion-start rise and no extra result. Busy stays high for CONV_CYC + 2*DATA_W*SCLK_DIV + 2 cycles and falls in the same edge that raises valid.
- R10: The serial clock stays high whenever neither select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Sample request, acted on only while idle |
| busy_o | output | 1 | High from the conversion-start rise until the pair is delivered |
| cnv_o | output | 1 | Shared conversion-start line |
| cs1_n_o | output | 1 | Active-low select of converter one |
| cs2_n_o | output | 1 | Active-low select of converter two |
| sclk_o | output | 1 | Shared serial clock, idle high |
| sdo_i | input | 1 | Shared serial data line from the converters |
| res1_o | output | DATA_W | Word read from converter one |
| res2_o | output | DATA_W | Word read from converter two |
| valid_o | output | 1 | One-cycle strobe marking a new result pair |

## Verification
The converter pair is modelled at the pins. Each model shifts its word out on falling clock edges and lets go of the line after its sixteenth edge. The words are chosen so that errors show up: all zeros against all ones tells a swapped converter order from a lost bit. Alternating patterns expose an off-by-one capture edge. Words with only the end bits set show whether bit order was reversed or an edge was dropped at the start or end of a read, and an irregular word catches any other slip. One sequence sends a second request in the middle of a read, which shows whether requests made while busy are dropped. For every pair the bench also measures the conversion wait, the clock edges in each window, the gap between selects and the length of busy.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_CONV = 3'd1,
    S_RD1  = 3'd2,
    S_GAP  = 3'd3,
    S_RD2  = 3'd4,
    S_FIN  = 3'd5
  } rd_state_t;
endpackage

// File: rtl/dsr_wait_timer.sv
module dsr_wait_timer #(
  parameter int CONV_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic done_o
);
  localparam int CW = (CONV_CYC < 2) ? 1 : $clog2(CONV_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(CONV_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == CNT_LAST) run_q <= 1'b0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = run_q && (cnt_q == CNT_LAST);
endmodule

// File: rtl/dsr_sclk_gen.sv
module dsr_sclk_gen #(
  parameter int DATA_W   = 16,
  parameter int SCLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic smp_o,
  output logic last_o
);
  localparam int PW = $clog2(SCLK_DIV);
  localparam int BW = (DATA_W < 2) ? 1 : $clog2(DATA_W);
  localparam logic [PW-1:0] PH_RISE = PW'(SCLK_DIV / 2);
  localparam logic [PW-1:0] PH_END  = PW'(SCLK_DIV - 1);
  localparam logic [BW-1:0] BIT_END = BW'(DATA_W - 1);

  logic [PW-1:0] ph_q;
  logic [BW-1:0] bit_q;
  logic          sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b1;
    end else if (!run_i) begin
      ph_q   <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      if (ph_q == '0)      sclk_q <= 1'b0;
      if (ph_q == PH_RISE) sclk_q <= 1'b1;
      if (ph_q == PH_END) begin
        ph_q  <= '0;
        bit_q <= (bit_q == BIT_END) ? '0 : bit_q + 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign sclk_o = sclk_q;
  assign smp_o  = run_i && (ph_q == '0);
  assign last_o = run_i && (ph_q == PH_END) && (bit_q == BIT_END);
endmodule

// File: rtl/dsr_shift_rx.sv
module dsr_shift_rx #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_i,
  input  logic              sdo_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (smp_i) sh_q <= {sh_q[DATA_W-2:0], sdo_i};
  end

  assign word_o = sh_q;
endmodule

// File: rtl/dual_sar_reader.sv
module dual_sar_reader
  import dsr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CONV_CYC = 40,
  parameter int SCLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              cnv_o,
  output logic              cs1_n_o,
  output logic              cs2_n_o,
  output logic              sclk_o,
  input  logic              sdo_i,
  output logic [DATA_W-1:0] res1_o,
  output logic [DATA_W-1:0] res2_o,
  output logic              valid_o
);
  rd_state_t         st_q;
  logic              cnv_q, cs1_q, cs2_q, busy_q, valid_q;
  logic [DATA_W-1:0] hold1_q, res1_q, res2_q;
  logic              accept, t_done, run, smp, last;
  logic [DATA_W-1:0] word;

  assign accept = (st_q == S_IDLE) && start_i;
  assign run    = (st_q == S_RD1) || (st_q == S_RD2);

  dsr_wait_timer #(.CONV_CYC(CONV_CYC)) u_wait (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .done_o(t_done)
  );

  dsr_sclk_gen #(.DATA_W(DATA_W), .SCLK_DIV(SCLK_DIV)) u_sclk (
    .clk(clk), .rst_n(rst_n), .run_i(run),
    .sclk_o(sclk_o), .smp_o(smp), .last_o(last)
  );

  dsr_shift_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .smp_i(smp), .sdo_i(sdo_i), .word_o(word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cnv_q   <= 1'b0;
      cs1_q   <= 1'b1;
      cs2_q   <= 1'b1;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      hold1_q <= '0;
      res1_q  <= '0;
      res2_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          cnv_q  <= 1'b1;
          busy_q <= 1'b1;
          st_q   <= S_CONV;
        end
        S_CONV: if (t_done) begin
          cs1_q <= 1'b0;
          st_q  <= S_RD1;
        end
        S_RD1: if (last) begin
          cs1_q   <= 1'b1;
          hold1_q <= word;
          st_q    <= S_GAP;
        end
        S_GAP: begin
          cs2_q <= 1'b0;
          st_q  <= S_RD2;
        end
        S_RD2: if (last) begin
          cs2_q <= 1'b1;
          st_q  <= S_FIN;
        end
        S_FIN: begin
          res1_q  <= hold1_q;
          res2_q  <= word;
          valid_q <= 1'b1;
          cnv_q   <= 1'b0;
          busy_q  <= 1'b0;
          st_q    <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o  = busy_q;
  assign cnv_o   = cnv_q;
  assign cs1_n_o = cs1_q;
  assign cs2_n_o = cs2_q;
  assign res1_o  = res1_q;
  assign res2_o  = res2_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/dsr_chk.sv
module dsr_chk #(
  parameter int CONV_CYC = 40,
  parameter int SCLK_DIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic cnv,
  input logic cs1_n,
  input logic cs2_n,
  input logic sclk,
  input logic busy,
  input logic valid
);
  logic [31:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      wait_q <= '0;
    else if (!cnv)                   wait_q <= '0;
    else if (wait_q != 32'hFFFF_FFFF) wait_q <= wait_q + 1;
  end

  initial begin
    p_div_min_r4: assert (SCLK_DIV >= 2);
  end

  p_conv_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs1_n) |-> (wait_q >= 32'(CONV_CYC)));

  p_sel_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs1_n || cs2_n));

  p_cnv_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cnv |-> (cs1_n && cs2_n));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> valid);

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv) |-> (busy && cs1_n && cs2_n));

  p_sclk_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs1_n && cs2_n) |-> sclk);
endmodule

bind dual_sar_reader dsr_chk #(.CONV_CYC(CONV_CYC), .SCLK_DIV(SCLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnv(cnv_o), .cs1_n(cs1_n_o), .cs2_n(cs2_n_o),
  .sclk(sclk_o), .busy(busy_o), .valid(valid_o)
);

// File: tb/sim_dual_sar_reader.sv
`timescale 1ns/1ps
module sim_dual_sar_reader;
  localparam int DW  = 16;
  localparam int CC  = 40;
  localparam int DIV = 4;
  localparam int BUSY_LEN = CC + 2 * DW * DIV + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, cnv, cs1_n, cs2_n, sclk, sdo, valid;
  logic [DW-1:0] res1, res2;

  always #5 clk = ~clk;

  dual_sar_reader #(.DATA_W(DW), .CONV_CYC(CC), .SCLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .cnv_o(cnv),
    .cs1_n_o(cs1_n), .cs2_n_o(cs2_n), .sclk_o(sclk), .sdo_i(sdo),
    .res1_o(res1), .res2_o(res2), .valid_o(valid)
  );

  // converter models
  logic [DW-1:0] word1 = '0, word2 = '0;
  int  idx1 = DW - 1, idx2 = DW - 1;
  bit  rel1 = 1'b1, rel2 = 1'b1;
  always @(negedge cs1_n) begin idx1 = DW - 1; rel1 = 1'b0; end
  always @(posedge cs1_n) rel1 = 1'b1;
  always @(negedge cs2_n) begin idx2 = DW - 1; rel2 = 1'b0; end
  always @(posedge cs2_n) rel2 = 1'b1;
  always @(negedge sclk) begin
    if (!cs1_n && !rel1) begin if (idx1 == 0) rel1 = 1'b1; else idx1--; end
    if (!cs2_n && !rel2) begin if (idx2 == 0) rel2 = 1'b1; else idx2--; end
  end
  wire drv1 = !cs1_n && !rel1;
  wire drv2 = !cs2_n && !rel2;
  assign sdo = drv1 ? word1[idx1] : (drv2 ? word2[idx2] : 1'b0);

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  // scoreboard queue
  logic [2*DW-1:0] exp_q[$];

  // monitor
  int  wait_c = 0, falls1 = 0, falls2 = 0, gap_c = 0, busy_c = 0;
  int  rises = 0, n_valid = 0, bad6 = 0, bad7 = 0, bad10 = 0, clash = 0;
  bit  seen1 = 1'b0, seen2 = 1'b0;
  logic p_sclk = 1'b1, p_cnv = 1'b0, p_valid = 1'b0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (busy) busy_c++;
      if (cnv && !p_cnv) begin
        rises++; seen1 = 1'b0; seen2 = 1'b0; wait_c = 0; gap_c = 0;
      end
      if (cnv && cs1_n && !seen1) wait_c++;
      if (!cs1_n) seen1 = 1'b1;
      if (seen1 && cnv && cs1_n && cs2_n && !seen2) gap_c++;
      if (!cs2_n) seen2 = 1'b1;
      if (p_sclk && !sclk) begin
        if (!cs1_n) falls1++;
        if (!cs2_n) falls2++;
      end
      if (!cs1_n && !cs2_n) bad6++;
      if (!cnv && (!cs1_n || !cs2_n)) bad7++;
      if (cs1_n && cs2_n && !sclk) bad10++;
      if (drv1 && drv2) clash++;
      if (valid) begin
        n_valid++;
        chk(!p_valid, "R8 valid width", 2, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected result", {res1, res2}, 0);
        end else begin
          logic [2*DW-1:0] e;
          e = exp_q.pop_front();
          chk(res1 == e[2*DW-1:DW], "R5 res1 word", res1, e[2*DW-1:DW]);
          chk(res2 == e[DW-1:0], "R8 res2 word", res2, e[DW-1:0]);
        end
        chk(wait_c == CC, "R3 conversion wait", wait_c, CC);
        chk(falls1 == DW, "R4 clock falls converter one", falls1, DW);
        chk(falls2 == DW, "R4 clock falls converter two", falls2, DW);
        chk(gap_c >= 1, "R6 gap between selects", gap_c, 1);
        chk(busy_c == BUSY_LEN, "R9 busy length", busy_c, BUSY_LEN);
        chk(!busy, "R9 busy low with valid", busy, 0);
        falls1 = 0; falls2 = 0; busy_c = 0;
      end
      p_sclk = sclk; p_cnv = cnv; p_valid = valid;
    end
  end

  // driver
  task automatic run_pair(input logic [DW-1:0] a, input logic [DW-1:0] b, input bit poke);
    @(negedge clk);
    while (busy) @(negedge clk);
    word1 = a; word2 = b;
    exp_q.push_back({a, b});
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cnv && busy, "R2 start raises cnv and busy", {cnv, busy}, 2'b11);
    if (poke) begin
      repeat (CC + 30) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs1_n && cs2_n, "R1 selects high in reset", {cs1_n, cs2_n}, 2'b11);
    chk(sclk, "R1 clock idle high", sclk, 1);
    chk(!cnv, "R1 conversion-start low", cnv, 0);
    chk(!busy && !valid, "R1 busy and valid low", {busy, valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sclk && cs1_n && cs2_n, "R10 idle pins after reset", {sclk, cs1_n, cs2_n}, 3'b111);

    run_pair(16'h0000, 16'hFFFF, 1'b0);
    run_pair(16'hAAAA, 16'h5555, 1'b0);
    run_pair(16'h8001, 16'h7FFE, 1'b1);
    run_pair(16'h1234, 16'hFEDC, 1'b0);
    run_pair(16'hFFFF, 16'h0001, 1'b0);
    repeat (DIV * DW * 3) @(negedge clk);

    chk(rises == 5, "R9 conversion-start rises", rises, 5);
    chk(n_valid == 5, "R9 result count", n_valid, 5);
    chk(exp_q.size() == 0, "R8 pending results", exp_q.size(), 0);
    chk(bad6 == 0 && clash == 0, "R6 selects overlap", bad6 + clash, 0);
    chk(bad7 == 0, "R7 cnv low with select", bad7, 0);
    chk(bad10 == 0, "R10 clock low while idle", bad10, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule